// File: doc/BRIEF.md
# Multi-channel event timer

This block is a memory-mapped event timer. A 64-bit main counter advances once per clock while a run bit is set. Several comparator channels watch it. Each channel holds a match value and raises its interrupt when the counter reaches that value. A channel fires either once (one-shot) or repeatedly: in periodic mode a reload period is added to the match value on every hit.

Software reaches every register through a simple 32-bit register bus. The registers are a capability word, a read-only tick period in femtoseconds, a general configuration word, a write-one-to-clear status word, the two counter halves, and per channel a configuration word and the two comparator halves. A single write with the set-value bit arms a two-step load: the next low comparator write sets the match value and the one after it sets the period. When a legacy routing bit is set, the interrupts of channels 0 and 1 move off the per-channel lines onto two fixed lines, a system tick line and a real-time-clock line.

Top module: `event_timer`

## Requirements
- R1: After reset the counter, general configuration and all status bits are 0. While the run bit (bit 0 of the general configuration at 0x010) is 1, the counter increases by exactly 1 per clock. While the run bit is 0 it holds its value.
- R2: The counter reads and writes as two 32-bit halves, low at 0xF0 and high at 0xF4. Writing zero to both halves while stopped and then setting run restarts counting from zero. A carry from the low half propagates into the high half.
- R3: The capability word at 0x000 reads bits [7:0]=0x01, bits [12:8]=channel count minus one, bit 13=1 (64-bit counter) and bit 15=1 (legacy routing available). The word at 0x004 reads the TICK_FS parameter.
- R4: Channel n has its configuration word at 0x100+0x20*n (bit 0 interrupt enable, bit 1 periodic, bit 3 32-bit mode) and its comparator halves at +0x08 and +0x0C. Comparators reset to all ones. A one-shot channel sets status bit n in the status word (0x020) after the clock edge at which the running counter equals its comparator, and does not fire again unless the counter returns to that value.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: A configuration write with both bit 2 (set-value) and bit 1 (periodic) set arms the channel. The next low comparator write loads the match value and the following one loads the period. In periodic mode every hit adds the period to the match value, so the channel fires at M, M+P and M+2P. Bit 2 reads back as 0.
- R7: A comparator half that has just been written reads back with the written value on the next bus read.
- R8: In 32-bit mode only the low 32 bits of the counter and the comparator are compared. The periodic addition wraps modulo 2^32 and leaves the high comparator half unchanged.
- R9: With the legacy bit (bit 1 of 0x010) set, tickIrq carries channel 0's interrupt, rtcIrq carries channel 1's interrupt, and irqOut[1:0] are held at 0. With the legacy bit clear, both legacy lines are 0.
- R10: A channel interrupt equals its status bit ANDed with its interrupt enable. With the enable clear, a hit sets status but the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | High the cycle after a read request |
| irqOut | output | NUM_CH | Per-channel interrupt lines |
| tickIrq | output | 1 | Legacy system tick interrupt (channel 0 when routed) |
| rtcIrq | output | 1 | Legacy real-time-clock interrupt (channel 1 when routed) |

## Verification
A wrong load-sequencer state shows up as a comparator that reads back with a value different from the one written. It can also show up as a match or period that lands in the wrong register, which the following comparator read and the next interrupt edge expose within a few cycles. A counter that skips or stalls moves every interrupt edge away from its computed cycle, so the bench samples each line one cycle before and one cycle after the expected hit. Routing faults are visible at once on the legacy and per-channel lines as soon as the legacy bit changes.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam int CNT_W  = 64;
  localparam int IDX_W  = 3;

  localparam logic [BUS_AW-1:0] ADDR_ID     = 12'h000;
  localparam logic [BUS_AW-1:0] ADDR_PERIOD = 12'h004;
  localparam logic [BUS_AW-1:0] ADDR_GCFG   = 12'h010;
  localparam logic [BUS_AW-1:0] ADDR_STAT   = 12'h020;
  localparam logic [BUS_AW-1:0] ADDR_CNT_LO = 12'h0F0;
  localparam logic [BUS_AW-1:0] ADDR_CNT_HI = 12'h0F4;
  localparam logic [3:0]        CH_PAGE     = 4'h1;
  localparam logic [4:0]        CH_CFG      = 5'h00;
  localparam logic [4:0]        CH_CMP_LO   = 5'h08;
  localparam logic [4:0]        CH_CMP_HI   = 5'h0C;

  localparam int CFG_IRQEN    = 0;
  localparam int CFG_PERIODIC = 1;
  localparam int CFG_SETVAL   = 2;
  localparam int CFG_MODE32   = 3;
  localparam int GCFG_RUN     = 0;
  localparam int GCFG_LEGACY  = 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_MATCH, SEQ_PERIOD} loadSeq_t;

  typedef struct packed {
    logic gcfgWr;
    logic cntLoWr;
    logic cntHiWr;
    logic statWr;
    logic rdReq;
  } glbStrobe_t;

  typedef struct packed {
    logic cfgWr;
    logic matchLoWr;
    logic matchHiWr;
    logic perLoWr;
    logic perHiWr;
  } chStrobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
`timescale 1ns/1ps
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [BUS_AW-1:0]        busAddr,
  input  logic [1:0]               seqBits,
  output glbStrobe_t               glb,
  output chStrobe_t [NUM_CH-1:0]   chs
);
  logic wrEn;
  logic inPage;
  logic [IDX_W-1:0] chIdx;
  logic [4:0] chReg;

  assign wrEn   = busSel & busWr;
  assign inPage = (busAddr[11:8] == CH_PAGE);
  assign chIdx  = busAddr[7:5];
  assign chReg  = busAddr[4:0];

  always_comb begin
    glb.gcfgWr  = wrEn && (busAddr == ADDR_GCFG);
    glb.cntLoWr = wrEn && (busAddr == ADDR_CNT_LO);
    glb.cntHiWr = wrEn && (busAddr == ADDR_CNT_HI);
    glb.statWr  = wrEn && (busAddr == ADDR_STAT);
    glb.rdReq   = busSel && !busWr;
  end

  // seqBits = {set-value, periodic} of the written config word
  for (genvar n = 0; n < NUM_CH; n++) begin : g_seq
    logic hit, cfgHit, loHit, hiHit;
    loadSeq_t seqQ;

    assign hit    = wrEn && inPage && (chIdx == IDX_W'(n));
    assign cfgHit = hit && (chReg == CH_CFG);
    assign loHit  = hit && (chReg == CH_CMP_LO);
    assign hiHit  = hit && (chReg == CH_CMP_HI);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        seqQ <= SEQ_IDLE;
      end else if (cfgHit) begin
        seqQ <= (seqBits == 2'b11) ? SEQ_MATCH : SEQ_IDLE;
      end else if (loHit) begin
        seqQ <= (seqQ == SEQ_MATCH) ? SEQ_PERIOD : SEQ_IDLE;
      end
    end

    assign chs[n] = '{cfgWr:     cfgHit,
                      matchLoWr: loHit && (seqQ != SEQ_PERIOD),
                      matchHiWr: hiHit && (seqQ != SEQ_PERIOD),
                      perLoWr:   loHit && (seqQ == SEQ_PERIOD),
                      perHiWr:   hiHit && (seqQ == SEQ_PERIOD)};
  end
endmodule

// File: rtl/evt_timer_dp.sv
`timescale 1ns/1ps
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int TICK_FS = 5_000_000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  glbStrobe_t               glb,
  input  chStrobe_t [NUM_CH-1:0]   chs,
  input  logic [BUS_AW-1:0]        busAddr,
  input  logic [BUS_DW-1:0]        busWdata,
  output logic [BUS_DW-1:0]        busRdata,
  output logic                     busRvalid,
  output logic [NUM_CH-1:0]        irqOut,
  output logic                     tickIrq,
  output logic                     rtcIrq,
  output logic [CNT_W-1:0]         cntVal,
  output logic                     runOn,
  output logic                     legacyOn
);
  localparam logic [BUS_DW-1:0] ID_WORD =
    {16'h0000, 1'b1, 1'b0, 1'b1, 5'(NUM_CH-1), 8'h01};

  logic [CNT_W-1:0] cnt;
  logic runBit, legBit;
  logic [NUM_CH-1:0] stat, hitVec, irqEnV, perV, m32V, live;
  logic [NUM_CH-1:0][CNT_W-1:0] matchQ, perQ;
  logic [BUS_DW-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (glb.cntLoWr) begin
      cnt[31:0] <= busWdata;
    end else if (glb.cntHiWr) begin
      cnt[63:32] <= busWdata;
    end else if (runBit) begin
      cnt <= cnt + 64'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0;
      legBit <= 1'b0;
    end else if (glb.gcfgWr) begin
      runBit <= busWdata[GCFG_RUN];
      legBit <= busWdata[GCFG_LEGACY];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic lowEq, fullEq;
    assign lowEq     = (cnt[31:0] == matchQ[n][31:0]);
    assign fullEq    = lowEq && (cnt[63:32] == matchQ[n][63:32]);
    assign hitVec[n] = runBit && (m32V[n] ? lowEq : fullEq);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irqEnV[n] <= 1'b0;
        perV[n]   <= 1'b0;
        m32V[n]   <= 1'b0;
      end else if (chs[n].cfgWr) begin
        irqEnV[n] <= busWdata[CFG_IRQEN];
        perV[n]   <= busWdata[CFG_PERIODIC];
        m32V[n]   <= busWdata[CFG_MODE32];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchQ[n] <= '1;
      end else if (chs[n].matchLoWr) begin
        matchQ[n][31:0] <= busWdata;
      end else if (chs[n].matchHiWr) begin
        matchQ[n][63:32] <= busWdata;
      end else if (hitVec[n] && perV[n]) begin
        if (m32V[n]) begin
          matchQ[n][31:0] <= matchQ[n][31:0] + perQ[n][31:0];
        end else begin
          matchQ[n] <= matchQ[n] + perQ[n];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        perQ[n] <= '0;
      end else if (chs[n].perLoWr) begin
        perQ[n][31:0] <= busWdata;
      end else if (chs[n].perHiWr) begin
        perQ[n][63:32] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat <= '0;
    end else begin
      stat <= (stat & ~(glb.statWr ? busWdata[NUM_CH-1:0] : '0)) | hitVec;
    end
  end

  assign live = stat & irqEnV;

  always_comb begin
    irqOut = live;
    if (legBit) irqOut[1:0] = 2'b00;
  end
  assign tickIrq = legBit & live[0];
  assign rtcIrq  = legBit & live[1];

  always_comb begin
    rdNext = '0;
    case (busAddr)
      ADDR_ID:     rdNext = ID_WORD;
      ADDR_PERIOD: rdNext = 32'(TICK_FS);
      ADDR_GCFG:   rdNext = {30'd0, legBit, runBit};
      ADDR_STAT:   rdNext = 32'(stat);
      ADDR_CNT_LO: rdNext = cnt[31:0];
      ADDR_CNT_HI: rdNext = cnt[63:32];
      default: begin
        if (busAddr[11:8] == CH_PAGE) begin
          for (int n = 0; n < NUM_CH; n++) begin
            if (busAddr[7:5] == IDX_W'(n)) begin
              case (busAddr[4:0])
                CH_CFG:    rdNext = {28'd0, m32V[n], 1'b0, perV[n], irqEnV[n]};
                CH_CMP_LO: rdNext = matchQ[n][31:0];
                CH_CMP_HI: rdNext = matchQ[n][63:32];
                default:   rdNext = '0;
              endcase
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= glb.rdReq;
      if (glb.rdReq) busRdata <= rdNext;
    end
  end

  assign cntVal   = cnt;
  assign runOn    = runBit;
  assign legacyOn = legBit;
endmodule

// File: rtl/event_timer.sv
`timescale 1ns/1ps
module event_timer
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int TICK_FS = 5_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [11:0]       busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  output logic [NUM_CH-1:0] irqOut,
  output logic              tickIrq,
  output logic              rtcIrq
);
  glbStrobe_t             glb;
  chStrobe_t [NUM_CH-1:0] chs;
  logic [CNT_W-1:0]       cntVal;
  logic                   runOn;
  logic                   legacyOn;

  evt_timer_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .seqBits(busWdata[CFG_SETVAL:CFG_PERIODIC]),
    .glb(glb), .chs(chs)
  );

  evt_timer_dp #(.NUM_CH(NUM_CH), .TICK_FS(TICK_FS)) u_dp (
    .clk(clk), .rstN(rstN), .glb(glb), .chs(chs),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .irqOut(irqOut), .tickIrq(tickIrq), .rtcIrq(rtcIrq),
    .cntVal(cntVal), .runOn(runOn), .legacyOn(legacyOn)
  );
endmodule

// File: rtl/event_timer_chk.sv
`timescale 1ns/1ps
module event_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [1:0]  legacyPair,
  input logic        tickIrq,
  input logic        rtcIrq,
  input logic [63:0] cntVal,
  input logic        runOn,
  input logic        legacyOn
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runOn) && !$past(busSel && busWr)) |-> (cntVal == $past(cntVal) + 64'd1));

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runOn) && !$past(busSel && busWr)) |-> $stable(cntVal));

  p_legacy_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    legacyOn |-> (legacyPair == 2'b00));

  p_legacy_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !legacyOn |-> (!tickIrq && !rtcIrq));
endmodule

bind event_timer event_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .legacyPair(irqOut[1:0]), .tickIrq(tickIrq), .rtcIrq(rtcIrq),
  .cntVal(cntVal), .runOn(runOn), .legacyOn(legacyOn)
);

// File: tb/event_timer_bench.sv
`timescale 1ns/1ps
module event_timer_bench;
  localparam int NCH = 3;
  localparam int TFS = 5_000_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busRvalid;
  logic [NCH-1:0] irqOut;
  logic tickIrq, rtcIrq;

  int nRun = 0;
  int nFail = 0;
  bit doneFlag = 1'b0;
  string expTag[$];
  logic [31:0] expVal[$];

  event_timer #(.NUM_CH(NCH), .TICK_FS(TFS)) u_event_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .irqOut(irqOut), .tickIrq(tickIrq), .rtcIrq(rtcIrq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // driver: queue the expected word, then issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    expTag.push_back(tag);
    expVal.push_back(e);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitc(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare each read response
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expVal.size() == 0) begin
        chk("unexpected read response", busRdata, 32'hxxxx_xxxx);
      end else begin
        chk(expTag.pop_front(), busRdata, expVal.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 reset irqOut", 32'(irqOut), 32'h0);
    rd(12'h010, 32'h0, "R1 reset gcfg");
    rd(12'h0F0, 32'h0, "R1 reset counter");
    rd(12'h020, 32'h0, "R1 reset status");

    // R3 capability and period
    rd(12'h000, 32'h0000_A001 | ((NCH - 1) << 8), "R3 capability word");
    rd(12'h004, 32'(TFS), "R3 tick period");

    // R1 counting and holding
    wr(12'h010, 32'h1);
    waitc(9);
    wr(12'h010, 32'h0);
    rd(12'h0F0, 32'd10, "R1 count after run");
    waitc(5);
    rd(12'h0F0, 32'd10, "R1 hold while stopped");

    // R2 halves, carry, restart
    wr(12'h0F4, 32'h7);
    wr(12'h0F0, 32'hFFFF_FFFE);
    rd(12'h0F4, 32'h7, "R2 high half write");
    wr(12'h010, 32'h1);
    waitc(2);
    wr(12'h010, 32'h0);
    rd(12'h0F0, 32'h1, "R2 low after carry");
    rd(12'h0F4, 32'h8, "R2 high after carry");
    wr(12'h0F0, 32'h0);
    wr(12'h0F4, 32'h0);
    rd(12'h0F0, 32'h0, "R2 restart low");
    rd(12'h0F4, 32'h0, "R2 restart high");

    // R4 one-shot channel 0
    wr(12'h108, 32'd20);
    wr(12'h10C, 32'd0);
    wr(12'h100, 32'h1);
    wr(12'h010, 32'h1);
    waitc(20);
    chk("R4 one-shot before match", 32'(irqOut), 32'h0);
    waitc(1);
    chk("R4 one-shot at match", 32'(irqOut), 32'h1);
    rd(12'h020, 32'h1, "R4 status only channel 0");
    // R5 write-one-to-clear
    wr(12'h020, 32'h0);
    rd(12'h020, 32'h1, "R5 write zero ignored");
    wr(12'h020, 32'h1);
    rd(12'h020, 32'h0, "R5 write one clears");
    waitc(20);
    rd(12'h020, 32'h0, "R4 no second fire");
    wr(12'h010, 32'h0);

    // R7 comparator readback
    wr(12'h128, 32'h1234_5678);
    rd(12'h128, 32'h1234_5678, "R7 low readback");
    wr(12'h12C, 32'hCAFE_0001);
    rd(12'h12C, 32'hCAFE_0001, "R7 high readback");

    // R6 periodic via set-value sequence on channel 0
    wr(12'h0F0, 32'h0);
    wr(12'h0F4, 32'h0);
    wr(12'h020, 32'h7);
    wr(12'h100, 32'h7);
    wr(12'h108, 32'd20);
    wr(12'h108, 32'd10);
    rd(12'h100, 32'h3, "R6 set-value reads zero");
    rd(12'h108, 32'd20, "R6 period write keeps match");
    wr(12'h010, 32'h1);
    waitc(20);
    chk("R6 before first hit", 32'(irqOut[0]), 32'h0);
    waitc(1);
    chk("R6 first hit", 32'(irqOut[0]), 32'h1);
    wr(12'h020, 32'h1);
    waitc(8);
    chk("R6 before second hit", 32'(irqOut[0]), 32'h0);
    waitc(1);
    chk("R6 second hit", 32'(irqOut[0]), 32'h1);
    wr(12'h010, 32'h0);
    rd(12'h108, 32'd40, "R6 match advanced by period");

    // R10 enable clear: status without line
    wr(12'h100, 32'h0);
    wr(12'h120, 32'h0);
    wr(12'h128, 32'd5);
    wr(12'h12C, 32'd0);
    wr(12'h020, 32'h7);
    wr(12'h0F0, 32'h0);
    wr(12'h010, 32'h1);
    waitc(10);
    chk("R10 line stays low", 32'(irqOut), 32'h0);
    wr(12'h010, 32'h0);
    rd(12'h020, 32'h2, "R10 status still set");

    // R9 legacy routing of channel 1
    wr(12'h020, 32'h7);
    wr(12'h0F0, 32'h0);
    wr(12'h120, 32'h1);
    wr(12'h128, 32'd3);
    wr(12'h010, 32'h1);
    waitc(10);
    chk("R9 direct line", 32'(irqOut), 32'h2);
    chk("R9 rtc quiet without legacy", 32'(rtcIrq), 32'h0);
    wr(12'h010, 32'h3);
    chk("R9 direct masked", 32'(irqOut), 32'h0);
    chk("R9 rtc line routed", 32'(rtcIrq), 32'h1);
    chk("R9 tick line idle", 32'(tickIrq), 32'h0);
    wr(12'h010, 32'h0);
    chk("R9 back to direct", 32'(irqOut), 32'h2);
    chk("R9 rtc released", 32'(rtcIrq), 32'h0);

    // R8 32-bit mode with wrapping period on channel 2
    wr(12'h120, 32'h0);
    wr(12'h020, 32'h7);
    wr(12'h0F0, 32'h0);
    wr(12'h0F4, 32'h0);
    wr(12'h140, 32'hF);
    wr(12'h14C, 32'd5);
    wr(12'h148, 32'd4);
    wr(12'h148, 32'hFFFF_FFFF);
    wr(12'h010, 32'h1);
    waitc(4);
    chk("R8 before low-word hit", 32'(irqOut[2]), 32'h0);
    waitc(1);
    chk("R8 low-word hit", 32'(irqOut[2]), 32'h1);
    wr(12'h010, 32'h0);
    rd(12'h148, 32'd3, "R8 low wraps");
    rd(12'h14C, 32'd5, "R8 high unchanged");

    waitc(3);
    chk("scoreboard drained", 32'(expVal.size()), 32'h0);
    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule